// File: doc/BRIEF.md
# Fixed-Page Stack Pointer

This block holds the 8-bit pointer of a 256-byte hardware stack that always occupies one memory page, 0x0100 through 0x01FF. The 16-bit stack address is built by placing a hardwired page byte (0x01) above the pointer, so the surrounding memory logic receives a full address without any arithmetic of its own.

Controlling microcode pushes a byte by asserting a push request during the write cycle. The write uses the current address, and the pointer then moves down by one. It pops a byte by asserting a pop request. The address already shows the pointer plus one in that same cycle, and the pointer moves up to it. A 16-bit return address is saved high byte first, then low byte, and is restored in the reverse order. The pointer can also be loaded from the data bus. Running off either end of the page wraps the pointer and sets a sticky flag that only reset clears.

Top module: `stack_ptr_page`

## Requirements
- R1: After reset is released, `ptr_o` is 0xFF and both `ovf_o` and `unf_o` are 0.
- R2: The upper byte of `addr_o` is always 0x01.
- R3: When push is the selected operation, `addr_o` is {0x01, ptr} in that same cycle, and `ptr_o` is ptr-1 one clock later.
- R4: When pop is the selected operation, `addr_o` is {0x01, ptr+1} in that same cycle, and `ptr_o` is ptr+1 one clock later.
- R5: Load has priority over push and pop. After `load_i` is sampled high, `ptr_o` equals the `data_i` value from that cycle.
- R6: When `push_i` and `pop_i` are both high without `load_i`, the push is performed and the pop request is ignored.
- R7: A push at ptr 0x00 wraps the pointer to 0xFF and sets `ovf_o` one clock later.
- R8: A pop at ptr 0xFF wraps the pointer to 0x00 and sets `unf_o` one clock later.
- R9: Once set, `ovf_o` and `unf_o` stay set until reset, including across loads.
- R10: With no request, `ptr_o` holds its value and `addr_o` is {0x01, ptr}.
- R11: A 16-bit value pushed high byte then low byte from reset occupies 0x01FF (high) and 0x01FE (low). It is popped low then high, and the pointer returns to 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push request; write at the current address, then decrement |
| pop_i | input | 1 | Pop request; increment, then read |
| load_i | input | 1 | Load the pointer from `data_i` |
| data_i | input | 8 | Data bus value for a load |
| ptr_o | output | 8 | Current pointer |
| addr_o | output | 16 | Stack address for memory access |
| ovf_o | output | 1 | Sticky flag: a push wrapped below 0x00 |
| unf_o | output | 1 | Sticky flag: a pop wrapped above 0xFF |

## Verification
`addr_o` is combinational, so it is due in the same cycle as the request. The bench drives requests on the falling edge and samples `addr_o` 2 ns later, before the rising edge. `ptr_o`, `ovf_o` and `unf_o` settle one rising edge after the request, and the bench samples them 2 ns after that edge. The pointer is swept over all 256 load values, with a push, a pop, a load-over-push and a push-with-pop case at each value. A bench memory driven by the pushed addresses checks the return-address ordering.

// File: rtl/stack_ptr_pkg.sv
package stack_ptr_pkg;
  typedef enum logic [1:0] {
    SP_IDLE = 2'd0,
    SP_PUSH = 2'd1,
    SP_POP  = 2'd2,
    SP_LOAD = 2'd3
  } sp_op_e;
endpackage

// File: rtl/stack_ptr_core.sv
module stack_ptr_core
  import stack_ptr_pkg::*;
#(
  parameter int unsigned PTR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  sp_op_e           op_i,
  input  logic [PTR_W-1:0] data_i,
  output logic [PTR_W-1:0] ptr_o
);
  logic [PTR_W-1:0] ptr_q, ptr_d;

  always_comb begin
    unique case (op_i)
      SP_PUSH: ptr_d = ptr_q - PTR_W'(1);
      SP_POP:  ptr_d = ptr_q + PTR_W'(1);
      SP_LOAD: ptr_d = data_i;
      default: ptr_d = ptr_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '1;
    else         ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;

  assert_push_dec_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == SP_PUSH |=> ptr_q == PTR_W'($past(ptr_q) - PTR_W'(1)));
  assert_pop_inc_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == SP_POP |=> ptr_q == PTR_W'($past(ptr_q) + PTR_W'(1)));
  assert_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == SP_LOAD |=> ptr_q == $past(data_i));
  assert_idle_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == SP_IDLE |=> $stable(ptr_q));
endmodule

// File: rtl/stack_ptr_flags.sv
module stack_ptr_flags
  import stack_ptr_pkg::*;
#(
  parameter int unsigned PTR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  sp_op_e           op_i,
  input  logic [PTR_W-1:0] ptr_i,
  output logic             ovf_o,
  output logic             unf_o
);
  logic ovf_q, unf_q;
  logic wrap_lo, wrap_hi;

  assign wrap_lo = (op_i == SP_PUSH) && (ptr_i == '0);
  assign wrap_hi = (op_i == SP_POP)  && (ptr_i == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      ovf_q <= ovf_q | wrap_lo;
      unf_q <= unf_q | wrap_hi;
    end
  end

  assign ovf_o = ovf_q;
  assign unf_o = unf_q;

  assert_ovf_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == SP_PUSH && ptr_i == '0) |=> ovf_q);
  assert_unf_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == SP_POP && ptr_i == '1) |=> unf_q);
  assert_ovf_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |=> ovf_q);
  assert_unf_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_q |=> unf_q);
endmodule

// File: rtl/stack_ptr_addr.sv
module stack_ptr_addr
  import stack_ptr_pkg::*;
#(
  parameter int unsigned PTR_W  = 8,
  parameter int unsigned PAGE_W = 8,
  parameter logic [PAGE_W-1:0] PAGE = 8'h01,
  localparam int unsigned ADDR_W = PAGE_W + PTR_W
) (
  input  sp_op_e            op_i,
  input  logic [PTR_W-1:0]  ptr_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [PTR_W-1:0] low;

  // pop is pre-increment: memory sees the next slot up in the same cycle
  assign low    = (op_i == SP_POP) ? ptr_i + PTR_W'(1) : ptr_i;
  assign addr_o = {PAGE, low};
endmodule

// File: rtl/stack_ptr_page.sv
module stack_ptr_page
  import stack_ptr_pkg::*;
#(
  parameter int unsigned PTR_W  = 8,
  parameter int unsigned PAGE_W = 8,
  parameter logic [PAGE_W-1:0] PAGE = 8'h01,
  localparam int unsigned ADDR_W = PAGE_W + PTR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic              load_i,
  input  logic [PTR_W-1:0]  data_i,
  output logic [PTR_W-1:0]  ptr_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              ovf_o,
  output logic              unf_o
);
  sp_op_e op;
  logic [PTR_W-1:0] ptr;

  // priority: load, push, pop
  always_comb begin
    if (load_i)      op = SP_LOAD;
    else if (push_i) op = SP_PUSH;
    else if (pop_i)  op = SP_POP;
    else             op = SP_IDLE;
  end

  stack_ptr_core #(.PTR_W(PTR_W)) u_core (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .op_i  (op),
    .data_i(data_i),
    .ptr_o (ptr)
  );

  stack_ptr_flags #(.PTR_W(PTR_W)) u_flags (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .op_i  (op),
    .ptr_i (ptr),
    .ovf_o (ovf_o),
    .unf_o (unf_o)
  );

  stack_ptr_addr #(.PTR_W(PTR_W), .PAGE_W(PAGE_W), .PAGE(PAGE)) u_addr (
    .op_i  (op),
    .ptr_i (ptr),
    .addr_o(addr_o)
  );

  assign ptr_o = ptr;

  assert_page_fixed_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_o[ADDR_W-1:PTR_W] == PAGE);
  assert_push_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && !load_i) |=> ptr_o == PTR_W'($past(ptr_o) - PTR_W'(1)));
  assert_push_addr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !load_i) |-> addr_o[PTR_W-1:0] == ptr_o);
endmodule

// File: tb/stack_ptr_page_test.sv
`timescale 1ns/1ps
module stack_ptr_page_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        push_i = 1'b0, pop_i = 1'b0, load_i = 1'b0;
  logic [7:0]  data_i = 8'h00;
  logic [7:0]  ptr_o;
  logic [15:0] addr_o;
  logic        ovf_o, unf_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_ptr;
  logic       exp_ovf, exp_unf;
  logic [7:0] mem [0:255];
  logic [15:0] seen_addr;

  always #10 clk_i = ~clk_i;

  stack_ptr_page uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(push_i), .pop_i(pop_i),
    .load_i(load_i), .data_i(data_i), .ptr_o(ptr_o), .addr_o(addr_o),
    .ovf_o(ovf_o), .unf_o(unf_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_state(input string req);
    check(ptr_o == exp_ptr, req, ptr_o, exp_ptr);
    check(ovf_o == exp_ovf, {req, " ovf R9"}, ovf_o, exp_ovf);
    check(unf_o == exp_unf, {req, " unf R9"}, unf_o, exp_unf);
  endtask

  // one request cycle: drive at negedge, address before posedge, state after posedge
  task automatic step(input bit psh, input bit pp, input bit ld, input logic [7:0] d,
                      input logic [7:0] wdata, input bit do_write);
    @(negedge clk_i);
    push_i = psh; pop_i = pp; load_i = ld; data_i = d;
    #2;
    seen_addr = addr_o;
    if (do_write) mem[addr_o[7:0]] = wdata;
    @(posedge clk_i);
    #2;
    push_i = 1'b0; pop_i = 1'b0; load_i = 1'b0;
    if (ld) exp_ptr = d;
    else if (psh) begin
      if (exp_ptr == 8'h00) exp_ovf = 1'b1;
      exp_ptr = exp_ptr - 8'd1;
    end else if (pp) begin
      if (exp_ptr == 8'hFF) exp_unf = 1'b1;
      exp_ptr = exp_ptr + 8'd1;
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (2) @(posedge clk_i);
    #2 rst_ni = 1'b1;
    exp_ptr = 8'hFF; exp_ovf = 1'b0; exp_unf = 1'b0;
    #1;
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] hi, lo;
    do_reset();
    check_state("R1 reset");
    check(addr_o == 16'h01FF, "R10 idle addr", addr_o, 16'h01FF);

    // R11: return address 0xBEEF, high then low
    step(1, 0, 0, 8'h00, 8'hBE, 1);
    check(seen_addr == 16'h01FF, "R11 push hi addr", seen_addr, 16'h01FF);
    step(1, 0, 0, 8'h00, 8'hEF, 1);
    check(seen_addr == 16'h01FE, "R11 push lo addr", seen_addr, 16'h01FE);
    check_state("R11 after push");
    step(0, 1, 0, 8'h00, 8'h00, 0);
    lo = mem[seen_addr[7:0]];
    check(seen_addr == 16'h01FE, "R11 pop lo addr", seen_addr, 16'h01FE);
    step(0, 1, 0, 8'h00, 8'h00, 0);
    hi = mem[seen_addr[7:0]];
    check({hi, lo} == 16'hBEEF, "R11 return value", {hi, lo}, 16'hBEEF);
    check_state("R11 ptr back");

    // idle hold
    step(0, 0, 0, 8'h5A, 8'h00, 0);
    check_state("R10 idle hold");
    check(seen_addr == 16'h01FF, "R10 idle addr", seen_addr, 16'h01FF);

    for (int v = 0; v < 256; v++) begin
      step(0, 0, 1, 8'(v), 8'h00, 0);
      check_state("R5 load");
      step(1, 0, 0, 8'h00, 8'h00, 0);
      check(seen_addr == {8'h01, 8'(v)}, "R3 push addr", seen_addr, {8'h01, 8'(v)});
      check(seen_addr[15:8] == 8'h01, "R2 page", seen_addr[15:8], 8'h01);
      check_state(v == 0 ? "R7 push wrap" : "R3 push ptr");
      step(0, 0, 1, 8'(v), 8'h00, 0);
      step(0, 1, 0, 8'h00, 8'h00, 0);
      check(seen_addr == {8'h01, 8'(v + 1)}, "R4 pop addr", seen_addr, {8'h01, 8'(v + 1)});
      check_state(v == 255 ? "R8 pop wrap" : "R4 pop ptr");
      step(1, 1, 1, 8'(255 - v), 8'h00, 0);
      check_state("R5 load priority");
      step(1, 1, 0, 8'h00, 8'h00, 0);
      check_state("R6 push over pop");
    end
    check(ovf_o && unf_o, "R9 both sticky", {ovf_o, unf_o}, 2'b11);

    do_reset();
    check_state("R1 reset clears flags");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule